// File: doc/BRIEF.md
# Talker Settling and Command Window Timer

This block times two windows for a parallel instrument bus (IEEE-488) port. When the talker side puts a byte on the data lines it pulses a strobe. The block then raises a settling pulse of fixed length. The data-valid line may be driven once that pulse ends, so the byte is stable on the bus before the listeners see it.

The second window serves the listener (slave) side. A rising edge on the received attention line opens an active-low window that is about one hundred times longer. During that window one command byte is accepted. The window is held back while the interrupt daisy-chain enable input is low. An attention edge that arrives in that state is kept pending, and the window opens as soon as the enable is seen high.

Both timers can be retriggered: a new trigger while a pulse is running starts that pulse over at full length. The lengths are parameters in clock cycles. Their defaults are worked out from a clock-frequency parameter, giving about 5 µs and 500 µs.

Top module: `gpib_pulse_timer`

## Requirements
- R1: Out of reset with no activity, `dav_go` is low and `cmd_win_n` is high. Both take these levels at once when `rst_n` goes low.
- R2: If `data_placed` is high at a clock edge, `dav_go` goes high in the next cycle and stays high for exactly SHORT_CYC cycles.
- R3: A `data_placed` strobe while `dav_go` is high restarts the pulse. `dav_go` then falls SHORT_CYC cycles after the last strobe.
- R4: If `atn_rx` rises (low at one edge, high at the next) while `chain_en` is high at that edge, `cmd_win_n` goes low in the next cycle for exactly LONG_CYC cycles.
- R5: While `chain_en` is low, no attention edge can pull `cmd_win_n` low.
- R6: An attention rising edge seen while `chain_en` is low is remembered. At the first later edge where `chain_en` is high, the window opens for LONG_CYC cycles, even if `atn_rx` has gone low by then.
- R7: A new attention rising edge during an open window, with `chain_en` high, restarts the window at full length.
- R8: Holding `atn_rx` high counts as one trigger only. The window closes after LONG_CYC cycles even if the line stays high.
- R9: Reset discards a pending attention request. After reset, raising `chain_en` alone opens no window.
- R10: The two timers are independent. Triggering both in the same cycle gives each its own full length.
- R11: Defaults are SHORT_CYC = CLK_HZ × 5 µs and LONG_CYC = CLK_HZ × 500 µs, rounded down to whole cycles. Both are at least 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released inside the block through two flops |
| data_placed | input | 1 | One-cycle strobe: a byte has just been put on the data lines |
| atn_rx | input | 1 | Received attention line, active high, already synchronous to `clk` |
| chain_en | input | 1 | Interrupt daisy-chain enable; while it is low the command window is held back |
| dav_go | output | 1 | Settling pulse, high while the data is settling; data-valid may be driven after it falls |
| cmd_win_n | output | 1 | Command acceptance window, low while it is open |

## Verification
The assertions assume that `atn_rx`, `chain_en` and `data_placed` are synchronous to `clk`. They also assume that a reset release reaches the timers only through the internal two-flop synchronizer. The bench changes every input on the falling clock edge and keeps them steady across the rising edge. The bench also holds all triggers idle for the synchronizer cycles after each reset release, so the reference model does not need to track that latency. Short lengths are set for the bench so that restarts, the pending-enable path and a held attention line all fit well inside the run.

// File: rtl/gpib_tmr_pkg.sv
package gpib_tmr_pkg;

  typedef enum logic {
    PULSE_HIGH = 1'b0,
    PULSE_LOW  = 1'b1
  } pulse_pol_e;

  // Whole clock cycles in a span of ns nanoseconds, never less than one (R11)
  function automatic int unsigned span_cycles(longint unsigned hz, longint unsigned ns);
    longint unsigned c;
    c = (hz * ns) / 64'd1_000_000_000;
    if (c == 0) c = 1;
    return int'(c);
  endfunction

endpackage

// File: rtl/gpt_retrig_timer.sv
module gpt_retrig_timer
  import gpib_tmr_pkg::*;
#(
  parameter int unsigned LEN = 8,
  parameter pulse_pol_e  POL = PULSE_HIGH
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trig,
  output logic pulse_o
);

  localparam int unsigned CW = $clog2(LEN + 1);
  localparam logic [CW-1:0] LOAD = CW'(LEN);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          running;
  logic          cnt_en;

  assign running = (cnt_q != '0);
  assign cnt_en  = trig | running;

  always_comb begin
    if (trig) cnt_d = LOAD;
    else      cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  generate
    if (POL == PULSE_LOW) begin : g_low
      assign pulse_o = ~running;
    end else begin : g_high
      assign pulse_o = running;
    end
  endgenerate

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LOAD); // R2

  AST_RETRIG_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    trig |=> (cnt_q == LOAD)); // R3

  AST_STEADY_DECAY: assert property (@(posedge clk) disable iff (!rst_n)
    (!trig && running) |=> (cnt_q == $past(cnt_q) - 1'b1)); // R4

  AST_IDLE_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
    (!trig && !running) |=> !running); // R1

endmodule

// File: rtl/gpt_atn_gate.sv
module gpt_atn_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic atn_i,
  input  logic en_i,
  output logic fire_o
);

  logic atn_q;
  logic pend_q, pend_d;
  logic rise;

  assign rise   = atn_i & ~atn_q;
  assign fire_o = en_i & (rise | pend_q);

  always_comb begin
    pend_d = (pend_q | rise) & ~fire_o;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      atn_q  <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      atn_q  <= atn_i;
      pend_q <= pend_d;
    end
  end

  AST_HOLD_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |-> !fire_o); // R5

  AST_PEND_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && en_i) |-> fire_o); // R6

  AST_PEND_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && !en_i) |=> pend_q); // R6

  AST_LEVEL_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    (atn_q && atn_i && !pend_q) |-> !fire_o); // R8

endmodule

// File: rtl/gpib_pulse_timer.sv
module gpib_pulse_timer
  import gpib_tmr_pkg::*;
#(
  parameter longint unsigned CLK_HZ    = 64'd200_000_000,
  parameter int unsigned     SHORT_CYC = span_cycles(CLK_HZ, 64'd5_000),
  parameter int unsigned     LONG_CYC  = span_cycles(CLK_HZ, 64'd500_000)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic data_placed,
  input  logic atn_rx,
  input  logic chain_en,
  output logic dav_go,
  output logic cmd_win_n
);

  logic [1:0] rst_pipe_q;
  logic       rst_int_n;
  logic       win_fire;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_int_n = rst_pipe_q[1];

  gpt_atn_gate u_gate (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .atn_i  (atn_rx),
    .en_i   (chain_en),
    .fire_o (win_fire)
  );

  gpt_retrig_timer #(.LEN(SHORT_CYC), .POL(PULSE_HIGH)) u_settle (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .trig    (data_placed),
    .pulse_o (dav_go)
  );

  gpt_retrig_timer #(.LEN(LONG_CYC), .POL(PULSE_LOW)) u_window (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .trig    (win_fire),
    .pulse_o (cmd_win_n)
  );

  AST_REST_IN_RESET: assert property (@(posedge clk)
    !rst_int_n |-> (!dav_go && cmd_win_n)); // R1

  AST_WIN_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_int_n)
    $fell(cmd_win_n) |-> $past(chain_en)); // R5

  AST_SETTLE_START: assert property (@(posedge clk) disable iff (!rst_int_n)
    data_placed |=> dav_go); // R2

  AST_TIMERS_APART: assert property (@(posedge clk) disable iff (!rst_int_n)
    (data_placed && !win_fire && cmd_win_n) |=> cmd_win_n); // R10

  initial begin
    AST_LEN_POSITIVE: assert (SHORT_CYC >= 1 && LONG_CYC >= 1); // R11
  end

endmodule

// File: tb/tb_gpib_pulse_timer.sv
`timescale 1ns/1ps
module tb_gpib_pulse_timer;

  localparam int SHORT = 6;
  localparam int LONG  = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic data_placed = 1'b0;
  logic atn_rx = 1'b0;
  logic chain_en = 1'b0;
  logic dav_go, cmd_win_n;

  int vectors = 0;
  int miscompares = 0;
  int cyc = 0;
  string req = "R1";

  // behavioural reference state
  int m_short = 0;
  int m_long = 0;
  bit m_pend = 0;
  bit m_prev = 0;

  always #2.5 clk = ~clk; // 200 MHz

  gpib_pulse_timer #(.CLK_HZ(64'd200_000_000), .SHORT_CYC(SHORT), .LONG_CYC(LONG)) dut (
    .clk(clk), .rst_n(rst_n), .data_placed(data_placed), .atn_rx(atn_rx),
    .chain_en(chain_en), .dav_go(dav_go), .cmd_win_n(cmd_win_n)
  );

  task automatic finish_run();
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  // reference model update on the rising edge, compare before the next falling edge
  always begin
    bit rise, start, exp_dav, exp_win_n;
    @(posedge clk);
    cyc++;
    if (!rst_n) begin
      m_short = 0; m_long = 0; m_pend = 0; m_prev = 0;
    end else begin
      rise  = atn_rx && !m_prev;
      start = chain_en && (rise || m_pend);
      m_pend = !start && (m_pend || rise);
      m_long  = start ? LONG : (m_long > 0 ? m_long - 1 : 0);
      m_short = data_placed ? SHORT : (m_short > 0 ? m_short - 1 : 0);
      m_prev = atn_rx;
    end
    #2;
    exp_dav   = rst_n && (m_short > 0);
    exp_win_n = !(rst_n && (m_long > 0));
    vectors++;
    if (dav_go !== exp_dav || cmd_win_n !== exp_win_n) begin
      miscompares++;
      $display("FAIL %s cycle %0d: dav_go=%b cmd_win_n=%b expected dav_go=%b cmd_win_n=%b",
               req, cyc, dav_go, cmd_win_n, exp_dav, exp_win_n);
    end
    if (cyc > 20000) begin
      miscompares++;
      $display("FAIL watchdog: run did not end, cycle %0d (actual running, expected done)", cyc);
      finish_run();
    end
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic strobe();
    @(negedge clk) data_placed = 1'b1;
    @(negedge clk) data_placed = 1'b0;
  endtask

  task automatic atn_pulse();
    @(negedge clk) atn_rx = 1'b1;
    @(negedge clk) atn_rx = 1'b0;
  endtask

  initial begin
    // R1: outputs at rest in and after reset
    req = "R1";
    idle(4);
    @(negedge clk) rst_n = 1'b1;
    idle(6);

    req = "R2";
    strobe();
    idle(SHORT + 4);

    req = "R3";
    strobe(); idle(2); strobe(); idle(3); strobe();
    idle(SHORT + 4);

    req = "R4";
    @(negedge clk) chain_en = 1'b1;
    atn_pulse();
    idle(LONG + 4);

    req = "R8";
    @(negedge clk) atn_rx = 1'b1;
    idle(LONG + 10);
    @(negedge clk) atn_rx = 1'b0;
    idle(3);

    req = "R5";
    @(negedge clk) chain_en = 1'b0;
    atn_pulse();
    idle(12);
    req = "R6";
    @(negedge clk) chain_en = 1'b1;
    idle(LONG + 4);

    req = "R7";
    atn_pulse();
    idle(8);
    atn_pulse();
    idle(LONG + 4);

    req = "R10";
    @(negedge clk) begin data_placed = 1'b1; atn_rx = 1'b1; end
    @(negedge clk) begin data_placed = 1'b0; atn_rx = 1'b0; end
    idle(LONG + 4);

    req = "R9";
    @(negedge clk) chain_en = 1'b0;
    atn_pulse();
    idle(3);
    @(negedge clk) rst_n = 1'b0;
    idle(3);
    @(negedge clk) rst_n = 1'b1;
    idle(4);
    @(negedge clk) chain_en = 1'b1;
    idle(LONG + 4);

    // R1: asynchronous reset during an active pulse returns outputs to rest
    req = "R1";
    strobe();
    @(negedge clk) atn_rx = 1'b1;
    @(negedge clk) atn_rx = 1'b0;
    idle(2);
    @(negedge clk) rst_n = 1'b0;
    idle(3);
    @(negedge clk) rst_n = 1'b1;
    idle(5);

    finish_run();
  end

endmodule